// File: doc/BRIEF.md
# SDRAM Read Burst Datapath Engine

This block is the device-side read path of a single-data-rate synchronous DRAM model. Each clock edge it decodes the command pins. When it sees a READ it captures the bank and starting column, then issues one column per cycle for the selected burst length. The words then pass through a CAS-latency delay line and are driven onto a tri-state data bus together with a bus-enable flag.

All read traffic shares one issue point and one fixed-depth delay line. A new READ therefore takes over from the current burst without a gap: fixed-length bursts can run back to back, and long bursts can be cut short. Full-page bursts circle through every column of the bank until another READ arrives. A per-command auto-precharge bit makes the engine pulse a per-bank "row closed" flag when a fixed-length burst finishes.

The CAS latency and burst length are static configuration inputs. The word store is loaded through a simple backdoor write port.

Top module: `sdram_read_engine`

## Requirements
- R1: A READ is taken only on an edge where cke=1, cs_n=0, ras_n=1, cas_n=0 and we_n=1. Every other pin combination (including cke=0, or cs_n=1) starts no burst and leaves the bus undriven.
- R2: cas_lat selects 1, 2 or 3 (value 0 acts as 1). The first word of a READ sampled at edge T is on dq with dq_oe=1 right after edge T+cas_lat.
- R3: blen_sel selects the burst length: 0 gives 1 word, 1 gives 2, 2 gives 4, 3 gives 8, 7 gives a full page, and 4 to 6 give 1. The setting is captured with each READ. Burst words follow one per clock with no gap.
- R4: A fixed-length burst steps upward through columns and wraps inside the aligned block of its own length (start column 6 with length 4 gives 6, 7, 4, 5). The bank comes from ba and the start column from col_addr, both sampled with the READ.
- R5: A full-page burst steps upward from the start column, wraps from the last column to column 0, and never ends unless another READ arrives.
- R6: A READ accepted at edge U ends the current burst. Its first word follows directly after the last word issued before U, so a READ placed exactly one burst length after the previous one gives an unbroken stream.
- R7: When no burst word is due, dq_oe is 0 and dq is high impedance. This starts on the cycle after the last word of a burst.
- R8: When auto_pre=1 with a fixed-length READ at edge T that runs to completion, pre_done[bank] is high for exactly the one cycle after edge T+burst length. There is no pulse when auto_pre=0, for full-page bursts, or when another READ cuts the burst short before its last word is issued. At most one bit of pre_done is high at a time.
- R9: With bd_we=1 at a clock edge, bd_data is written to the word at bd_bank/bd_col. Later READs return the new value.
- R10: A synchronous reset with rst_n=0 takes dq_oe and pre_done low after the edge and discards any burst in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| cke | input | 1 | Clock-enable pin; low blocks command decode |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe pin |
| cas_n | input | 1 | Column strobe pin |
| we_n | input | 1 | Write-enable pin |
| ba | input | BA_W | Bank address sampled with READ |
| col_addr | input | COL_W | Starting column sampled with READ |
| auto_pre | input | 1 | Auto-precharge request sampled with READ |
| cas_lat | input | CL_W | Static CAS latency setting |
| blen_sel | input | 3 | Static burst length code |
| bd_we | input | 1 | Backdoor write strobe |
| bd_bank | input | BA_W | Backdoor bank |
| bd_col | input | COL_W | Backdoor column |
| bd_data | input | DATA_W | Backdoor write data |
| dq | output | DATA_W | Data bus, high impedance when not driven |
| dq_oe | output | 1 | High while dq carries a burst word |
| pre_done | output | 2**BA_W | One-cycle per-bank auto-precharge completion pulse |

## Verification
The bench targets these cases:
- Block wrap at an unaligned start column. A design that wrapped at the page edge would return the wrong columns.
- Page wrap from column 255 to 0. A design that stopped or overflowed would drop the bus or read the wrong bank.
- READs spaced exactly one burst apart, and a READ landing mid-burst. A latency off by one shows up as a gap, an overlap or a stale word.
- An auto-precharge burst truncated by a later READ. A design that flags the close anyway emits an unexpected pulse.
- Each latency setting, and every non-READ pin pattern. A wrong setting shifts the first word, and a loose decode drives the bus when it should stay idle.

// File: rtl/sdrd_pkg.sv
// Shared definitions for the SDRAM read engine: burst length codes and the
// helper that turns a code into the column wrap mask.
package sdrd_pkg;

    typedef enum logic [2:0] {
        BLEN_1    = 3'd0,
        BLEN_2    = 3'd1,
        BLEN_4    = 3'd2,
        BLEN_8    = 3'd3,
        BLEN_PAGE = 3'd7
    } blen_e;

    // Burst length minus one, which is also the in-block wrap mask.
    function automatic logic [2:0] blen_mask(input logic [2:0] sel);
        case (sel)
            BLEN_2:  return 3'd1;
            BLEN_4:  return 3'd3;
            BLEN_8:  return 3'd7;
            default: return 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/sdrd_cmd_decode.sv
// Command decoder: flags a READ from the control pins.
// Assumes the pins are stable around the rising edge. Any pattern other
// than the READ pattern is treated as a NOP. Reset suppresses decode.
module sdrd_cmd_decode (
    input  logic rst_n,
    input  logic cke,
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output logic rd_go
);

    // READ pattern match, gated by clock enable and reset.
    always_comb begin
        rd_go = rst_n && cke && !cs_n && ras_n && !cas_n && we_n;
    end

endmodule

// File: rtl/sdrd_burst_seq.sv
// Burst sequencer: produces one issued column per cycle for the current
// burst. A new READ always replaces the running burst. Fixed bursts wrap in
// their aligned block; full-page bursts wrap over the whole row.
// Raises a one-cycle per-bank precharge pulse when an auto-precharge burst
// issues its last column. Assumes COL_W >= 3.
module sdrd_burst_seq
    import sdrd_pkg::*;
#(
    parameter  int BA_W  = 1,
    parameter  int COL_W = 8,
    localparam int BANKS = 1 << BA_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_go,
    input  logic [BA_W-1:0]  rd_bank,
    input  logic [COL_W-1:0] rd_col,
    input  logic             rd_ap,
    input  logic [2:0]       blen_sel,
    output logic             iss_valid,
    output logic [BA_W-1:0]  iss_bank,
    output logic [COL_W-1:0] iss_col,
    output logic [BANKS-1:0] pre_pulse
);

    logic [2:0]       rem_q;
    logic [2:0]       wmask_q;
    logic             full_q;
    logic             ap_q;
    logic [COL_W-1:0] mask_ext;
    logic [COL_W-1:0] next_col;
    logic             last_w;

    // Next column: whole-row increment or increment inside the block.
    always_comb begin
        mask_ext = {{(COL_W-3){1'b0}}, wmask_q};
        next_col = full_q ? iss_col + 1'b1
                          : (iss_col & ~mask_ext) | ((iss_col + 1'b1) & mask_ext);
        last_w   = iss_valid && !full_q && (rem_q == 3'd0);
    end

    // Burst state: load on READ, advance while words remain, else idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iss_valid <= 1'b0;
            iss_bank  <= '0;
            iss_col   <= '0;
            rem_q     <= '0;
            wmask_q   <= '0;
            full_q    <= 1'b0;
            ap_q      <= 1'b0;
        end else if (rd_go) begin
            iss_valid <= 1'b1;
            iss_bank  <= rd_bank;
            iss_col   <= rd_col;
            rem_q     <= blen_mask(blen_sel);
            wmask_q   <= blen_mask(blen_sel);
            full_q    <= (blen_sel == BLEN_PAGE);
            ap_q      <= rd_ap;
        end else if (iss_valid && !last_w) begin
            iss_col <= next_col;
            if (!full_q) rem_q <= rem_q - 3'd1;
        end else begin
            iss_valid <= 1'b0;
        end
    end

    // Per-bank precharge pulse, one register per bank.
    for (genvar b = 0; b < BANKS; b++) begin : g_pre
        always_ff @(posedge clk) begin
            if (!rst_n) pre_pulse[b] <= 1'b0;
            else        pre_pulse[b] <= last_w && ap_q && (iss_bank == BA_W'(b));
        end
    end

    // R4: a fixed burst stays inside its aligned column block.
    assert_block_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && !full_q && rem_q != 3'd0 && !rd_go)
        |=> (iss_valid && ((iss_col & ~mask_ext) == ($past(iss_col) & ~mask_ext))));

    // R5: a full-page burst wraps from the top column to column 0.
    assert_page_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && full_q && (&iss_col) && !rd_go) |=> (iss_valid && iss_col == '0));

    // R7: nothing is issued after the last word unless a new READ came.
    assert_burst_stops_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (last_w && !rd_go) |=> !iss_valid);

endmodule

// File: rtl/sdrd_lat_pipe.sv
// CAS-latency delay line: carries issued {valid, bank, column} through
// up to MAX_CL-1 register stages and taps the stage chosen by the latency.
// Assumes the latency input is static while a burst is in flight.
module sdrd_lat_pipe #(
    parameter  int BA_W   = 1,
    parameter  int COL_W  = 8,
    parameter  int CL_W   = 2,
    localparam int MAX_CL = (1 << CL_W) - 1,
    localparam int SW     = 1 + BA_W + COL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CL_W-1:0]  cas_lat,
    input  logic             in_valid,
    input  logic [BA_W-1:0]  in_bank,
    input  logic [COL_W-1:0] in_col,
    output logic             tap_valid,
    output logic [BA_W-1:0]  tap_bank,
    output logic [COL_W-1:0] tap_col
);

    logic [SW-1:0] head;
    logic [SW-1:0] dly [1:MAX_CL-1];
    logic [SW-1:0] tap;

    assign head = {in_valid, in_bank, in_col};

    // Delay stages; only the valid bit needs a reset value.
    for (genvar k = 1; k < MAX_CL; k++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) dly[k] <= '0;
            else if (k == 1) dly[k] <= head;
            else             dly[k] <= dly[(k > 1) ? k - 1 : 1];
        end
    end

    // Tap selection: latency 0 or 1 uses the undelayed issue stage.
    always_comb begin
        if (cas_lat <= CL_W'(1)) tap = head;
        else                     tap = dly[cas_lat - CL_W'(1)];
        {tap_valid, tap_bank, tap_col} = tap;
    end

endmodule

// File: rtl/sdram_read_engine.sv
// SDRAM read burst engine top: command decode, burst sequencing, CAS
// latency delay, word store with backdoor write, and the output register
// that drives the tri-state data bus. Assumes an open row in every bank
// and static latency / burst-length configuration.
module sdram_read_engine #(
    parameter  int DATA_W = 16,
    parameter  int BA_W   = 1,
    parameter  int COL_W  = 8,
    parameter  int CL_W   = 2,
    localparam int BANKS  = 1 << BA_W,
    localparam int COLS   = 1 << COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cke,
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [BA_W-1:0]   ba,
    input  logic [COL_W-1:0]  col_addr,
    input  logic              auto_pre,
    input  logic [CL_W-1:0]   cas_lat,
    input  logic [2:0]        blen_sel,
    input  logic              bd_we,
    input  logic [BA_W-1:0]   bd_bank,
    input  logic [COL_W-1:0]  bd_col,
    input  logic [DATA_W-1:0] bd_data,
    output logic [DATA_W-1:0] dq,
    output logic              dq_oe,
    output logic [BANKS-1:0]  pre_done
);

    logic              rd_go;
    logic              iss_valid;
    logic [BA_W-1:0]   iss_bank;
    logic [COL_W-1:0]  iss_col;
    logic              tap_valid;
    logic [BA_W-1:0]   tap_bank;
    logic [COL_W-1:0]  tap_col;
    logic [DATA_W-1:0] q_r;
    logic [DATA_W-1:0] mem [BANKS][COLS];

    sdrd_cmd_decode u_dec (
        .rst_n (rst_n), .cke (cke), .cs_n (cs_n), .ras_n (ras_n),
        .cas_n (cas_n), .we_n (we_n), .rd_go (rd_go)
    );

    sdrd_burst_seq #(.BA_W(BA_W), .COL_W(COL_W)) u_seq (
        .clk (clk), .rst_n (rst_n), .rd_go (rd_go), .rd_bank (ba),
        .rd_col (col_addr), .rd_ap (auto_pre), .blen_sel (blen_sel),
        .iss_valid (iss_valid), .iss_bank (iss_bank), .iss_col (iss_col),
        .pre_pulse (pre_done)
    );

    sdrd_lat_pipe #(.BA_W(BA_W), .COL_W(COL_W), .CL_W(CL_W)) u_pipe (
        .clk (clk), .rst_n (rst_n), .cas_lat (cas_lat),
        .in_valid (iss_valid), .in_bank (iss_bank), .in_col (iss_col),
        .tap_valid (tap_valid), .tap_bank (tap_bank), .tap_col (tap_col)
    );

    // Backdoor store write.
    always_ff @(posedge clk) begin
        if (bd_we) mem[bd_bank][bd_col] <= bd_data;
    end

    // Output register: fetch the tapped word and flag the bus as driven.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dq_oe <= 1'b0;
            q_r   <= '0;
        end else begin
            dq_oe <= tap_valid;
            if (tap_valid) q_r <= mem[tap_bank][tap_col];
        end
    end

    // Tri-state bus driver.
    assign dq = dq_oe ? q_r : 'z;

    // R2: first word appears exactly cas_lat edges after the READ edge.
    assert_lat1_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rd_go, 2) && cas_lat <= CL_W'(1)) |-> dq_oe);
    assert_lat2_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rd_go, 3) && cas_lat == CL_W'(2)) |-> dq_oe);
    assert_lat3_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rd_go, 4) && cas_lat == CL_W'(3)) |-> dq_oe);

    // R8: never more than one bank flagged as precharged at a time.
    assert_pre_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pre_done));

    // R7: a tapped word is always driven on the next cycle.
    assert_tap_drives_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tap_valid |=> dq_oe);

endmodule

// File: tb/tb_sdram_read_engine.sv
`timescale 1ns/1ps
module tb_sdram_read_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [0:0]  ba = '0;
    logic [7:0]  col_addr = '0;
    logic        auto_pre = 1'b0;
    logic [1:0]  cas_lat = 2'd1;
    logic [2:0]  blen_sel = 3'd0;
    logic        bd_we = 1'b0;
    logic [0:0]  bd_bank = '0;
    logic [7:0]  bd_col = '0;
    logic [15:0] bd_data = '0;
    logic [15:0] dq;
    logic        dq_oe;
    logic [1:0]  pre_done;

    sdram_read_engine dut (
        .clk (clk), .rst_n (rst_n), .cke (cke), .cs_n (cs_n), .ras_n (ras_n),
        .cas_n (cas_n), .we_n (we_n), .ba (ba), .col_addr (col_addr),
        .auto_pre (auto_pre), .cas_lat (cas_lat), .blen_sel (blen_sel),
        .bd_we (bd_we), .bd_bank (bd_bank), .bd_col (bd_col), .bd_data (bd_data),
        .dq (dq), .dq_oe (dq_oe), .pre_done (pre_done)
    );

    always #2.5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit mon_on = 1'b0;
    bit done = 1'b0;

    logic [15:0] shadow [2][256];
    logic [15:0] exp_word [int];
    string       exp_tag  [int];
    logic [1:0]  exp_pre  [int];
    int          pend_e = 0;
    bit          pend_v = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual %h expected %h (edge %0d)", tag, act, expv, cyc);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic nop_pins();
        cke = 1'b1; cs_n = 1'b1; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1;
    endtask

    // Driver: issue one READ on the coming edge and push expectations.
    task automatic rd(input int bank, input int col, input bit ap, input string tag);
        int t0, clv, first, n, c, m;
        int dk[$];
        bit full;
        t0 = cyc + 1;
        cs_n = 1'b0; ras_n = 1'b1; cas_n = 1'b0; we_n = 1'b1; cke = 1'b1;
        ba = bank[0:0]; col_addr = col[7:0]; auto_pre = ap;
        clv = (cas_lat == 2'd0) ? 1 : int'(cas_lat);
        first = t0 + clv;
        foreach (exp_word[k]) if (k >= first) dk.push_back(k);
        foreach (dk[i]) begin exp_word.delete(dk[i]); exp_tag.delete(dk[i]); end
        if (pend_v && t0 <= pend_e - 1) exp_pre.delete(pend_e);
        pend_v = 1'b0;
        full = (blen_sel == 3'd7);
        case (blen_sel)
            3'd1: m = 1;
            3'd2: m = 3;
            3'd3: m = 7;
            default: m = 0;
        endcase
        n = full ? 300 : m + 1;
        c = col;
        for (int i = 0; i < n; i++) begin
            exp_word[first + i] = shadow[bank][c];
            exp_tag[first + i] = tag;
            c = full ? ((c + 1) % 256) : ((c & ~m) | ((c + 1) & m));
        end
        if (!full && ap) begin
            pend_e = t0 + m + 1;
            pend_v = 1'b1;
            exp_pre[pend_e] = 2'(1 << bank);
        end
        @(negedge clk);
        nop_pins();
    endtask

    task automatic bd_write(input int bank, input int col, input logic [15:0] d);
        bd_we = 1'b1; bd_bank = bank[0:0]; bd_col = col[7:0]; bd_data = d;
        shadow[bank][col] = d;
        @(negedge clk);
        bd_we = 1'b0;
    endtask

    // Monitor: compare bus and precharge flags every cycle.
    always @(negedge clk) begin
        if (mon_on) begin
            if (exp_word.exists(cyc)) begin
                chk({exp_tag[cyc], " bus enable"}, 32'(dq_oe), 32'd1);
                chk({exp_tag[cyc], " data"}, 32'(dq), 32'(exp_word[cyc]));
                exp_word.delete(cyc);
                exp_tag.delete(cyc);
            end else begin
                chk("R7 idle bus", 32'(dq_oe), 32'd0);
            end
            chk("R8 precharge", 32'(pre_done), exp_pre.exists(cyc) ? 32'(exp_pre[cyc]) : 32'd0);
            if (exp_pre.exists(cyc)) exp_pre.delete(cyc);
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
            summary();
        end
    end

    initial begin
        // R10: reset state.
        repeat (4) @(negedge clk);
        chk("R10 reset oe", 32'(dq_oe), 32'd0);
        chk("R10 reset pre", 32'(pre_done), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: preload through the backdoor.
        for (int b = 0; b < 2; b++)
            for (int c = 0; c < 256; c++)
                bd_write(b, c, 16'(b * 16'h1000) ^ 16'(c * 16'h0101) ^ 16'h5A3C);
        mon_on = 1'b1;

        // R4: latency 1, length 4, unaligned start.
        cas_lat = 2'd1; blen_sel = 3'd2;
        rd(0, 6, 1'b0, "R4");
        idle(8);

        // R2 / R8: latency 2, length 8, auto-precharge.
        cas_lat = 2'd2; blen_sel = 3'd3;
        rd(1, 8'h13, 1'b1, "R2 cl2");
        idle(14);

        // R2: latency 3, single word at top column.
        cas_lat = 2'd3; blen_sel = 3'd0;
        rd(0, 255, 1'b0, "R2 cl3");
        idle(8);

        // R3: length 2 and a reserved code acting as 1.
        cas_lat = 2'd1; blen_sel = 3'd1;
        rd(1, 8'h41, 1'b0, "R3 len2");
        idle(5);
        blen_sel = 3'd5;
        rd(0, 9, 1'b1, "R3 len1");
        idle(6);

        // R1: non-READ pin patterns.
        cs_n = 1'b0; ras_n = 1'b1; cas_n = 1'b0; we_n = 1'b0; @(negedge clk);
        cs_n = 1'b0; ras_n = 1'b0; cas_n = 1'b1; we_n = 1'b1; @(negedge clk);
        cke = 1'b0; cs_n = 1'b0; ras_n = 1'b1; cas_n = 1'b0; we_n = 1'b1; @(negedge clk);
        cke = 1'b1; cs_n = 1'b1; @(negedge clk);
        nop_pins();
        idle(6);
        chk("R1 no burst after non-READ", 32'(dq_oe), 32'd0);

        // R6: back-to-back completed bursts, latency 2 length 4.
        cas_lat = 2'd2; blen_sel = 3'd2;
        rd(0, 8'h20, 1'b1, "R6 first");
        idle(3);
        rd(1, 8'h30, 1'b1, "R6 second");
        idle(10);

        // R6 / R8: truncate an auto-precharge burst, latency 3.
        cas_lat = 2'd3; blen_sel = 3'd3;
        rd(1, 8'h50, 1'b1, "R6 cut");
        idle(2);
        rd(0, 8'h60, 1'b0, "R6 taker");
        idle(14);

        // R9: backdoor overwrite seen by a later READ.
        bd_write(0, 3, 16'hBEEF);
        cas_lat = 2'd1; blen_sel = 3'd0;
        rd(0, 3, 1'b0, "R9");
        idle(5);

        // R5: full page wraps 255 -> 0, then a short READ ends it.
        cas_lat = 2'd2; blen_sel = 3'd7;
        rd(1, 8'hFA, 1'b1, "R5");
        idle(12);
        blen_sel = 3'd2;
        rd(0, 8'h80, 1'b0, "R5 end");
        idle(10);

        // R10: reset in the middle of a full-page burst.
        blen_sel = 3'd7;
        rd(0, 8'h10, 1'b0, "R10 pre-reset");
        idle(5);
        mon_on = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        chk("R10 oe after reset", 32'(dq_oe), 32'd0);
        chk("R10 pre after reset", 32'(pre_done), 32'd0);
        exp_word.delete(); exp_tag.delete(); exp_pre.delete(); pend_v = 1'b0;
        idle(2);
        rst_n = 1'b1;
        mon_on = 1'b1;
        idle(8);

        done = 1'b1;
        summary();
    end

endmodule